// File: doc/BRIEF.md
# Conditional Jump Evaluation Unit

This block sits beside the sequencer of a list-driven bus controller. Each 16-bit list word handed to it is sorted into one of three kinds: a dataway command, a stop, or a jump. For a command it splits out the function, subaddress, station and Q-ignore fields. For a jump it works out whether the branch is taken, and it raises the requests that go with it: wait for a new trigger, reload the write pointer, and hold both data pointers still.

Jump tests use two things. The first is the Q response of the most recent bus cycle. The second is an unsigned comparison between the data captured by the most recent read cycle and a 24-bit comparator value that the host loads. When a branch is taken, the 11-bit destination is zero-extended and presented as the instruction pointer load value in the same clock as the take strobe. At any other time that value holds, whatever the host writes.

Top module: `cju_top`

## Requirements
- R1: One clock after `instr_valid`, `res_valid` pulses for one cycle and `res_kind` gives the class of the word. The class is 2'b10 (jump) when instr[15] and instr[14] are both 1, 2'b01 (stop) when instr[15]=1 and instr[14]=0, and 2'b00 (command) when instr[15]=0. Bits here count from 0, so instr[15] is the top bit.
- R2: With the same timing, `cmd_func`=instr[4:0], `cmd_sub`=instr[8:5], `cmd_stn`=instr[13:9] and `cmd_qign`=instr[14].
- R3: A jump with condition code instr[13:11] equal to 3'b000, 3'b100 or 3'b111 is always taken.
- R4: A jump with code 3'b001 or 3'b101 is taken only when the last recorded Q is 0.
- R5: Codes 3'b010, 3'b011 and 3'b110 are taken when the captured read data is greater than, less than or equal to the comparator value. The comparison is unsigned over 24 bits.
- R6: A completed bus cycle (`cyc_done`) always records `cyc_q`. It captures `cyc_rdata` only when cyc_func[4] and cyc_func[3] are both 0. Each captured value and each host load applies to jumps presented in a later cycle.
- R7: For a taken jump, `take_jump` pulses together with `res_valid` and `jump_addr` becomes {5'b0, instr[10:0]} in that same cycle. Without a taken jump, `jump_addr` keeps its value.
- R8: `await_trig` pulses only for taken jumps with code 3'b100 or 3'b101. `restore_wp` pulses only for code 3'b111.
- R9: `ptr_inhibit` pulses with `res_valid` for every stop and jump, whether taken or not. It stays 0 for commands.
- R10: A host comparator write, including one in the same cycle as a jump evaluation, never changes `jump_addr`.
- R11: After reset, `res_valid`, `take_jump`, `await_trig`, `restore_wp` and `ptr_inhibit` are 0, `jump_addr` is 0, the comparator and the captured data are 0, and the last Q is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host strobe that loads the comparator value |
| host_wr_data | input | 24 | Comparator value from the host |
| cyc_done | input | 1 | A bus cycle has completed |
| cyc_func | input | 5 | Function code of the completed cycle |
| cyc_q | input | 1 | Q response of the completed cycle |
| cyc_rdata | input | 24 | Data returned by the completed cycle |
| instr_valid | input | 1 | List word is presented for evaluation |
| instr | input | 16 | List word |
| res_valid | output | 1 | Evaluation result strobe |
| res_kind | output | 2 | Class of the word: 00 command, 01 stop, 10 jump |
| cmd_func | output | 5 | Function field |
| cmd_sub | output | 4 | Subaddress field |
| cmd_stn | output | 5 | Station field |
| cmd_qign | output | 1 | Q-ignore flag |
| take_jump | output | 1 | Jump taken |
| jump_addr | output | 16 | Instruction pointer load value |
| await_trig | output | 1 | Request to stop and wait for a trigger |
| restore_wp | output | 1 | Request to reload the write pointer |
| ptr_inhibit | output | 1 | Hold both data pointers |

## Verification
The hardest cases to reach are the ones where the compare conditions sit at their edges: data exactly equal to the comparator, and values one apart across the byte-chunk boundaries of the split comparator. Random 24-bit values almost never produce these. The bench therefore often loads the comparator with the captured value itself, or with that value plus or minus one, and also runs directed all-zero and all-one cases. A further collision case is built on purpose: a host write lands in the same cycle as a taken or untaken jump, and a write-cycle function code arrives whose data must not be captured.

// File: rtl/cju_pkg.sv
package cju_pkg;

   typedef enum logic [1:0] {
      KIND_CMD  = 2'b00,
      KIND_STOP = 2'b01,
      KIND_JUMP = 2'b10
   } kind_e;

   localparam logic [2:0] JC_ALWAYS   = 3'b000;
   localparam logic [2:0] JC_NOQ      = 3'b001;
   localparam logic [2:0] JC_GT       = 3'b010;
   localparam logic [2:0] JC_LT       = 3'b011;
   localparam logic [2:0] JC_WAIT     = 3'b100;
   localparam logic [2:0] JC_NOQ_WAIT = 3'b101;
   localparam logic [2:0] JC_EQ       = 3'b110;
   localparam logic [2:0] JC_RESTORE  = 3'b111;

endpackage

// File: rtl/cju_decode.sv
module cju_decode
   import cju_pkg::*;
#(
   parameter int INSTR_W = 16,
   parameter int ADDR_W  = 11
) (
   input  logic [INSTR_W-1:0] word,
   output kind_e              kind,
   output logic [4:0]         func,
   output logic [3:0]         sub,
   output logic [4:0]         stn,
   output logic               qign,
   output logic [2:0]         jcode,
   output logic [ADDR_W-1:0]  jdest
);
   localparam int TOP_B  = INSTR_W - 1;
   localparam int SEL_B  = INSTR_W - 2;
   localparam int JC_LSB = ADDR_W;

   generate
      if (INSTR_W != 16) begin : g_bad_iw
         $error("cju_decode: list word must be 16 bits");
      end
      if (ADDR_W + 3 + 2 != INSTR_W) begin : g_bad_aw
         $error("cju_decode: destination width does not fit the jump layout");
      end
   endgenerate

   always_comb begin
      if (!word[TOP_B])      kind = KIND_CMD;
      else if (word[SEL_B])  kind = KIND_JUMP;
      else                   kind = KIND_STOP;
   end

   assign func  = word[4:0];
   assign sub   = word[8:5];
   assign stn   = word[13:9];
   assign qign  = word[SEL_B];
   assign jcode = word[JC_LSB+2:JC_LSB];
   assign jdest = word[ADDR_W-1:0];

endmodule

// File: rtl/cju_capture.sv
module cju_capture #(
   parameter int DATA_W = 24,
   parameter int FUNC_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr_en,
   input  logic [DATA_W-1:0] host_wr_data,
   input  logic              cyc_done,
   input  logic [FUNC_W-1:0] cyc_func,
   input  logic              cyc_q,
   input  logic [DATA_W-1:0] cyc_rdata,
   output logic [DATA_W-1:0] cmp_val,
   output logic [DATA_W-1:0] rd_val,
   output logic              last_q
);
   localparam int WR_B  = FUNC_W - 1;
   localparam int CTL_B = FUNC_W - 2;

   generate
      if (FUNC_W < 5) begin : g_bad_fw
         $error("cju_capture: function code too narrow");
      end
   endgenerate

   logic is_read;
   assign is_read = !cyc_func[WR_B] && !cyc_func[CTL_B];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_val <= '0;
         rd_val  <= '0;
         last_q  <= 1'b1;
      end else begin
         if (host_wr_en)           cmp_val <= host_wr_data;
         if (cyc_done)             last_q  <= cyc_q;
         if (cyc_done && is_read)  rd_val  <= cyc_rdata;
      end
   end

endmodule

// File: rtl/cju_compare.sv
module cju_compare #(
   parameter int DATA_W  = 24,
   parameter int CHUNK_W = 8,
   parameter bit SPLIT   = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic              gt,
   output logic              lt,
   output logic              eq
);
   localparam int NCHUNK = DATA_W / CHUNK_W;

   generate
      if (SPLIT) begin : g_split
         if (DATA_W % CHUNK_W != 0) begin : g_bad_chunk
            $error("cju_compare: data width must be a multiple of chunk width");
         end
         logic [NCHUNK-1:0] c_gt;
         logic [NCHUNK-1:0] c_eq;
         for (genvar i = 0; i < NCHUNK; i++) begin : g_chunk
            assign c_gt[i] = a[i*CHUNK_W +: CHUNK_W] > b[i*CHUNK_W +: CHUNK_W];
            assign c_eq[i] = a[i*CHUNK_W +: CHUNK_W] == b[i*CHUNK_W +: CHUNK_W];
         end
         always_comb begin
            logic g_acc;
            logic e_acc;
            g_acc = 1'b0;
            e_acc = 1'b1;
            for (int k = NCHUNK - 1; k >= 0; k--) begin
               g_acc = g_acc | (e_acc & c_gt[k]);
               e_acc = e_acc & c_eq[k];
            end
            gt = g_acc;
            eq = e_acc;
         end
      end else begin : g_flat
         assign gt = a > b;
         assign eq = a == b;
      end
   endgenerate

   assign lt = !gt && !eq;

endmodule

// File: rtl/cju_cond.sv
module cju_cond
   import cju_pkg::*;
(
   input  logic [2:0] jcode,
   input  logic       last_q,
   input  logic       gt,
   input  logic       lt,
   input  logic       eq,
   output logic       taken,
   output logic       wait_req,
   output logic       restore_req
);
   always_comb begin
      taken       = 1'b0;
      wait_req    = 1'b0;
      restore_req = 1'b0;
      case (jcode)
         JC_ALWAYS:   taken = 1'b1;
         JC_NOQ:      taken = !last_q;
         JC_GT:       taken = gt;
         JC_LT:       taken = lt;
         JC_WAIT: begin
            taken    = 1'b1;
            wait_req = 1'b1;
         end
         JC_NOQ_WAIT: begin
            taken    = !last_q;
            wait_req = !last_q;
         end
         JC_EQ:       taken = eq;
         JC_RESTORE: begin
            taken       = 1'b1;
            restore_req = 1'b1;
         end
         default:     taken = 1'b0;
      endcase
   end

endmodule

// File: rtl/cju_top.sv
module cju_top
   import cju_pkg::*;
#(
   parameter int DATA_W    = 24,
   parameter int INSTR_W   = 16,
   parameter int ADDR_W    = 11,
   parameter int IP_W      = 16,
   parameter int CHUNK_W   = 8,
   parameter bit CMP_SPLIT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_wr_en,
   input  logic [DATA_W-1:0]  host_wr_data,
   input  logic               cyc_done,
   input  logic [4:0]         cyc_func,
   input  logic               cyc_q,
   input  logic [DATA_W-1:0]  cyc_rdata,
   input  logic               instr_valid,
   input  logic [INSTR_W-1:0] instr,
   output logic               res_valid,
   output logic [1:0]         res_kind,
   output logic [4:0]         cmd_func,
   output logic [3:0]         cmd_sub,
   output logic [4:0]         cmd_stn,
   output logic               cmd_qign,
   output logic               take_jump,
   output logic [IP_W-1:0]    jump_addr,
   output logic               await_trig,
   output logic               restore_wp,
   output logic               ptr_inhibit
);
   localparam int PAD_W = IP_W - ADDR_W;

   generate
      if (IP_W < ADDR_W) begin : g_bad_ip
         $error("cju_top: pointer narrower than jump destination");
      end
   endgenerate

   kind_e             d_kind;
   logic [4:0]        d_func;
   logic [3:0]        d_sub;
   logic [4:0]        d_stn;
   logic              d_qign;
   logic [2:0]        d_jcode;
   logic [ADDR_W-1:0] d_jdest;

   logic [DATA_W-1:0] cmp_val;
   logic [DATA_W-1:0] rd_val;
   logic              last_q;
   logic              c_gt, c_lt, c_eq;
   logic              e_taken, e_wait, e_restore;

   cju_decode #(.INSTR_W(INSTR_W), .ADDR_W(ADDR_W)) u_dec (
      .word  (instr),
      .kind  (d_kind),
      .func  (d_func),
      .sub   (d_sub),
      .stn   (d_stn),
      .qign  (d_qign),
      .jcode (d_jcode),
      .jdest (d_jdest)
   );

   cju_capture #(.DATA_W(DATA_W), .FUNC_W(5)) u_cap (
      .clk          (clk),
      .rst_n        (rst_n),
      .host_wr_en   (host_wr_en),
      .host_wr_data (host_wr_data),
      .cyc_done     (cyc_done),
      .cyc_func     (cyc_func),
      .cyc_q        (cyc_q),
      .cyc_rdata    (cyc_rdata),
      .cmp_val      (cmp_val),
      .rd_val       (rd_val),
      .last_q       (last_q)
   );

   cju_compare #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W), .SPLIT(CMP_SPLIT)) u_cmp (
      .a  (rd_val),
      .b  (cmp_val),
      .gt (c_gt),
      .lt (c_lt),
      .eq (c_eq)
   );

   cju_cond u_cond (
      .jcode       (d_jcode),
      .last_q      (last_q),
      .gt          (c_gt),
      .lt          (c_lt),
      .eq          (c_eq),
      .taken       (e_taken),
      .wait_req    (e_wait),
      .restore_req (e_restore)
   );

   logic is_jump;
   assign is_jump = instr_valid && (d_kind == KIND_JUMP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_kind    <= KIND_CMD;
         cmd_func    <= '0;
         cmd_sub     <= '0;
         cmd_stn     <= '0;
         cmd_qign    <= 1'b0;
         take_jump   <= 1'b0;
         await_trig  <= 1'b0;
         restore_wp  <= 1'b0;
         ptr_inhibit <= 1'b0;
      end else begin
         res_valid   <= instr_valid;
         take_jump   <= is_jump && e_taken;
         await_trig  <= is_jump && e_taken && e_wait;
         restore_wp  <= is_jump && e_restore;
         ptr_inhibit <= instr_valid && (d_kind != KIND_CMD);
         if (instr_valid) begin
            res_kind <= d_kind;
            cmd_func <= d_func;
            cmd_sub  <= d_sub;
            cmd_stn  <= d_stn;
            cmd_qign <= d_qign;
         end
      end
   end

   // The pointer load value has its own enable: only a taken jump loads it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   jump_addr <= '0;
      else if (is_jump && e_taken)  jump_addr <= {{PAD_W{1'b0}}, d_jdest};
   end

endmodule

// File: rtl/cju_checker.sv
module cju_checker #(
   parameter int DATA_W  = 24,
   parameter int INSTR_W = 16,
   parameter int IP_W    = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               host_wr_en,
   input logic [DATA_W-1:0]  host_wr_data,
   input logic               instr_valid,
   input logic [INSTR_W-1:0] instr,
   input logic               res_valid,
   input logic [1:0]         res_kind,
   input logic               take_jump,
   input logic [IP_W-1:0]    jump_addr,
   input logic               await_trig,
   input logic               restore_wp,
   input logic               ptr_inhibit,
   input logic [DATA_W-1:0]  cmp_val
);
   AST_RES_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(instr_valid)); // R1

   AST_JUMP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && $past(instr[15]) && $past(instr[14])) |-> (res_kind == 2'b10)); // R1

   AST_UNCOND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_kind == 2'b10 && $past(instr[13:11]) == 3'b000) |-> take_jump); // R3

   AST_TAKE_IS_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
      take_jump |-> (res_valid && res_kind == 2'b10)); // R7

   AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      take_jump |-> (jump_addr == {{(IP_W-11){1'b0}}, $past(instr[10:0])})); // R7

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !take_jump |-> $stable(jump_addr)); // R7

   AST_AWAIT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      await_trig |-> take_jump); // R8

   AST_RESTORE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      restore_wp |-> (take_jump && $past(instr[13:11]) == 3'b111)); // R8

   AST_INHIBIT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_kind == 2'b00) |-> !ptr_inhibit); // R9

   AST_INHIBIT_NONCMD: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_kind != 2'b00) |-> ptr_inhibit); // R9

   AST_HOST_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr_en |=> (take_jump || $stable(jump_addr))); // R10

   AST_CMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr_en |=> (cmp_val == $past(host_wr_data))); // R6

endmodule

bind cju_top cju_checker #(.DATA_W(DATA_W), .INSTR_W(INSTR_W), .IP_W(IP_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .host_wr_en   (host_wr_en),
   .host_wr_data (host_wr_data),
   .instr_valid  (instr_valid),
   .instr        (instr),
   .res_valid    (res_valid),
   .res_kind     (res_kind),
   .take_jump    (take_jump),
   .jump_addr    (jump_addr),
   .await_trig   (await_trig),
   .restore_wp   (restore_wp),
   .ptr_inhibit  (ptr_inhibit),
   .cmp_val      (cmp_val)
);

// File: tb/sim_cju_top.sv
module sim_cju_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr_en = 1'b0;
   logic [23:0] host_wr_data = '0;
   logic        cyc_done = 1'b0;
   logic [4:0]  cyc_func = '0;
   logic        cyc_q = 1'b0;
   logic [23:0] cyc_rdata = '0;
   logic        instr_valid = 1'b0;
   logic [15:0] instr = '0;
   logic        res_valid;
   logic [1:0]  res_kind;
   logic [4:0]  cmd_func;
   logic [3:0]  cmd_sub;
   logic [4:0]  cmd_stn;
   logic        cmd_qign;
   logic        take_jump;
   logic [15:0] jump_addr;
   logic        await_trig;
   logic        restore_wp;
   logic        ptr_inhibit;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   // bench model state
   logic [23:0] m_cmp = '0;
   logic [23:0] m_rd = '0;
   logic        m_q = 1'b1;
   logic [15:0] m_addr = '0;

   always #5 clk = ~clk;

   cju_top u0 (
      .clk(clk), .rst_n(rst_n),
      .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
      .cyc_done(cyc_done), .cyc_func(cyc_func), .cyc_q(cyc_q), .cyc_rdata(cyc_rdata),
      .instr_valid(instr_valid), .instr(instr),
      .res_valid(res_valid), .res_kind(res_kind),
      .cmd_func(cmd_func), .cmd_sub(cmd_sub), .cmd_stn(cmd_stn), .cmd_qign(cmd_qign),
      .take_jump(take_jump), .jump_addr(jump_addr),
      .await_trig(await_trig), .restore_wp(restore_wp), .ptr_inhibit(ptr_inhibit)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] f_kind(input logic [15:0] w);
      if (!w[15]) return 2'b00;
      if (w[14])  return 2'b10;
      return 2'b01;
   endfunction

   function automatic bit f_taken(input logic [2:0] c);
      case (c)
         3'b000, 3'b100, 3'b111: return 1'b1;
         3'b001, 3'b101:         return !m_q;
         3'b010:                 return m_rd > m_cmp;
         3'b011:                 return m_rd < m_cmp;
         default:                return m_rd == m_cmp;
      endcase
   endfunction

   task automatic host_write(input logic [23:0] d);
      @(negedge clk);
      host_wr_en = 1'b1; host_wr_data = d;
      @(negedge clk);
      host_wr_en = 1'b0;
      m_cmp = d;
   endtask

   task automatic bus_cycle(input logic [4:0] f, input logic q, input logic [23:0] d);
      @(negedge clk);
      cyc_done = 1'b1; cyc_func = f; cyc_q = q; cyc_rdata = d;
      @(negedge clk);
      cyc_done = 1'b0;
      m_q = q;
      if (!f[4] && !f[3]) m_rd = d;
   endtask

   // present one word, optionally with a colliding host write; check results
   task automatic exec(input logic [15:0] w, input bit with_wr, input logic [23:0] wd);
      logic [1:0] ek;
      bit         et;
      ek = f_kind(w);
      et = (ek == 2'b10) && f_taken(w[13:11]);
      @(negedge clk);
      instr_valid = 1'b1; instr = w;
      host_wr_en = with_wr; host_wr_data = wd;
      @(negedge clk);
      instr_valid = 1'b0; host_wr_en = 1'b0;
      if (with_wr) m_cmp = wd;
      if (et) m_addr = {5'b0, w[10:0]};
      chk(res_valid == 1'b1, "R1 res_valid", res_valid, 1);
      chk(res_kind == ek, "R1 kind", res_kind, ek);
      if (ek == 2'b00) begin
         chk({cmd_func, cmd_sub, cmd_stn, cmd_qign} == {w[4:0], w[8:5], w[13:9], w[14]},
             "R2 fields", {cmd_func, cmd_sub, cmd_stn, cmd_qign}, {w[4:0], w[8:5], w[13:9], w[14]});
      end
      chk(take_jump == et, (w[13:11] inside {3'b010, 3'b011, 3'b110}) ? "R5 take" :
          (w[13:11] inside {3'b001, 3'b101}) ? "R4 take" : "R3 take", take_jump, et);
      chk(jump_addr == m_addr, with_wr ? "R10 addr" : "R7 addr", jump_addr, m_addr);
      chk(await_trig == (et && w[13:11] inside {3'b100, 3'b101}), "R8 await", await_trig,
          et && w[13:11] inside {3'b100, 3'b101});
      chk(restore_wp == (ek == 2'b10 && w[13:11] == 3'b111), "R8 restore", restore_wp,
          ek == 2'b10 && w[13:11] == 3'b111);
      chk(ptr_inhibit == (ek != 2'b00), "R9 inhibit", ptr_inhibit, ek != 2'b00);
      @(negedge clk);
      chk(res_valid == 1'b0 && take_jump == 1'b0, "R1 pulse", {res_valid, take_jump}, 0);
   endtask

   function automatic logic [15:0] jw(input logic [2:0] c, input logic [10:0] a);
      return {2'b11, c, a};
   endfunction

   initial begin
      repeat (1000000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 32'h5eed1;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      chk(res_valid == 0 && take_jump == 0 && await_trig == 0 && restore_wp == 0 && ptr_inhibit == 0,
          "R11 reset outputs", {res_valid, take_jump, await_trig, restore_wp, ptr_inhibit}, 0);
      chk(jump_addr == 16'h0, "R11 reset addr", jump_addr, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // r11_ reset: compare state 0==0 and Q=1
      exec(jw(3'b110, 11'h123), 1'b0, 24'h0);   // R11 equal after reset -> taken
      exec(jw(3'b001, 11'h055), 1'b0, 24'h0);   // R11 last Q 1 -> not taken
      // directed: classes and fields
      exec(16'h7ABC, 1'b0, 24'h0);              // R2 command with qign
      exec(16'h8001, 1'b0, 24'h0);              // stop
      exec(jw(3'b000, 11'h7FF), 1'b0, 24'h0);   // R3
      exec(jw(3'b100, 11'h001), 1'b0, 24'h0);   // R8 await
      exec(jw(3'b111, 11'h2AA), 1'b0, 24'h0);   // R8 restore
      // R4 no-Q
      bus_cycle(5'd0, 1'b0, 24'h000100);
      exec(jw(3'b001, 11'h111), 1'b0, 24'h0);
      exec(jw(3'b101, 11'h222), 1'b0, 24'h0);
      // R6 write-cycle data not captured (F16 and F8 functions)
      bus_cycle(5'd16, 1'b1, 24'hFFFFFF);
      bus_cycle(5'd8, 1'b1, 24'hFFFFFF);
      host_write(24'h000100);
      exec(jw(3'b110, 11'h333), 1'b0, 24'h0);   // R6 still 0x100 -> equal
      // R5 chunk boundaries
      bus_cycle(5'd2, 1'b1, 24'h010000);
      host_write(24'h00FFFF);
      exec(jw(3'b010, 11'h044), 1'b0, 24'h0);
      exec(jw(3'b011, 11'h045), 1'b0, 24'h0);
      host_write(24'hFFFFFF);
      exec(jw(3'b011, 11'h046), 1'b0, 24'h0);
      exec(jw(3'b010, 11'h047), 1'b0, 24'h0);
      // R10 collisions: host write with taken and not-taken jumps
      exec(jw(3'b110, 11'h3FF), 1'b1, 24'h010000);
      exec(jw(3'b110, 11'h3FE), 1'b1, 24'h123456);
      // random mix
      for (int i = 0; i < 3000; i++) begin
         int op;
         op = $urandom_range(0, 5);
         if (op == 0) begin
            int s;
            s = $urandom_range(0, 3);
            host_write(s == 0 ? m_rd : s == 1 ? m_rd + 24'd1 : s == 2 ? m_rd - 24'd1 : 24'($urandom));
         end else if (op == 1) begin
            bus_cycle(5'($urandom), 1'($urandom), 24'($urandom));
         end else begin
            logic [15:0] w;
            w = 16'($urandom);
            if (op >= 3) w[15:14] = 2'b11;
            exec(w, ($urandom_range(0, 7) == 0), 24'($urandom));
         end
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule